// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the addressing stage of a slave on a single-wire open-drain bus. It sits on top of a bit transceiver, which turns line activity into three single-cycle events: a bus reset was seen, a bit was written by the master, or the master opened a read slot. After every bus reset the layer collects one 8-bit ROM command, least significant bit first, and acts on it. It can send out the 64-bit device identifier, compare an identifier sent by the master, take part in the bitwise search, or select itself with no identifier exchange.

When addressing succeeds, `selected_o` rises and control passes to the function-command layer. Search cycles never select the device. They always end in the wait-for-reset state. During every read slot the transceiver samples `tx_drive_o` and `tx_bit_o`. It pulls the line low only when both the drive flag is set and the bit is 0.

Top module: `sw_rom_cmd`

## Requirements
- R1: After `rst_ni` the layer waits for a bus reset. `selected_o` and `tx_drive_o` are low, and written bits received before the first `bus_reset_i` are ignored.
- R2: After a bus reset, eight written bits form the command, first bit = bit 0. Opcode 0xCC raises `selected_o` in the cycle after the eighth bit, and it stays high until the next bus reset.
- R3: Opcode 0x33 drives identifier bits 0 to 63 in order, one per read slot, with `tx_drive_o` high. After the 64th slot `selected_o` is high.
- R4: Opcode 0x55 followed by 64 written bits equal to identifier bits 0 to 63 raises `selected_o` after the 64th bit.
- R5: During opcode 0x55, a written bit that differs from the identifier bit at that position sends the layer to wait-for-reset. Later bits are ignored, `selected_o` stays low and nothing is driven.
- R6: Opcode 0xF0 runs the search. For each identifier bit k, the first read slot drives bit k, the second drives its complement, and then a written bit equal to bit k moves the layer on to bit k+1.
- R7: In a search, a written direction bit that differs from identifier bit k drops the layer to wait-for-reset, and no later read slot is driven.
- R8: After the 64th direction bit of a search, the layer waits for reset with `selected_o` low and drives no read slot.
- R9: Opcode 0xEC behaves like 0xF0 when `alarm_i` is high at decode. When `alarm_i` is low it goes to wait-for-reset and drives nothing.
- R10: Any other opcode goes to wait-for-reset. `tx_drive_o` and `selected_o` stay low until the next bus reset.
- R11: `bus_reset_i` in any state clears `selected_o` and `tx_drive_o` in the next cycle and restarts command reception. A fresh 0xCC then selects the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | One-cycle pulse: bus reset detected |
| rx_valid_i | input | 1 | One-cycle pulse: master wrote a bit |
| rx_bit_i | input | 1 | Value of the written bit |
| rd_req_i | input | 1 | One-cycle pulse: read slot consumed |
| alarm_i | input | 1 | Alarm flag, sampled when an alarm search is decoded |
| id_i | input | 64 | Device identifier, bit 0 sent first |
| tx_drive_o | output | 1 | The layer takes part in the current read slot |
| tx_bit_o | output | 1 | Value for the current read slot |
| selected_o | output | 1 | Device addressed; function commands may follow |

## Verification
Every event pulse is taken at one clock edge. The state it causes, and therefore `selected_o`, `tx_drive_o` and `tx_bit_o`, is visible one cycle later. The bench drives each pulse high for exactly one cycle from a falling edge. It reads the read-slot value on the falling edge at which it raises `rd_req_i`, because that value must already be stable before the slot is consumed. It checks `selected_o` and the drive flag on the falling edge after the pulse that completes a command, a match or a search, which is the first point at which the new state can be seen.

// File: rtl/sw_rom_pkg.sv
package sw_rom_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
  localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
  localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
  localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;
  localparam logic [CMD_W-1:0] OP_ALARM  = 8'hEC;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_S_TRUE,
    ST_S_CMP,
    ST_S_DIR,
    ST_SEL
  } rom_st_e;
endpackage

// File: rtl/sw_rom_cmd_rx.sv
module sw_rom_cmd_rx #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic         done_o,
  output logic [W-1:0] byte_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;

  // lsb first: new bit enters at the top and moves down
  assign byte_o = {bit_i, sr_q[W-1:1]};
  assign done_o = en_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      sr_q  <= byte_o;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sw_rom_id_ptr.sv
module sw_rom_id_ptr #(
  parameter int ID_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            inc_i,
  input  logic [ID_W-1:0] id_i,
  output logic            bit_o,
  output logic            last_o
);
  localparam int IW = $clog2(ID_W);
  localparam logic [IW-1:0] LAST = IW'(ID_W - 1);

  logic [IW-1:0] idx_q;

  assign bit_o  = id_i[idx_q];
  assign last_o = (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (inc_i)  idx_q <= last_o ? '0 : idx_q + 1'b1;
  end
endmodule

// File: rtl/sw_rom_fsm.sv
module sw_rom_fsm
  import sw_rom_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_reset_i,
  input  logic             rx_valid_i,
  input  logic             rx_bit_i,
  input  logic             rd_req_i,
  input  logic             alarm_i,
  input  logic             cmd_done_i,
  input  logic [CMD_W-1:0] cmd_byte_i,
  input  logic             id_bit_i,
  input  logic             id_last_i,
  output rom_st_e          st_o,
  output logic             cmd_en_o,
  output logic             ptr_clr_o,
  output logic             ptr_inc_o,
  output logic             tx_drive_o,
  output logic             tx_bit_o,
  output logic             selected_o
);
  rom_st_e st_q, st_d;

  assign st_o     = st_q;
  assign cmd_en_o = (st_q == ST_CMD) && rx_valid_i;

  always_comb begin
    st_d      = st_q;
    ptr_clr_o = 1'b0;
    ptr_inc_o = 1'b0;
    if (bus_reset_i) begin
      st_d      = ST_CMD;
      ptr_clr_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_CMD: if (cmd_done_i) begin
          ptr_clr_o = 1'b1;
          unique case (cmd_byte_i)
            OP_SEARCH: st_d = ST_S_TRUE;
            OP_ALARM:  st_d = alarm_i ? ST_S_TRUE : ST_WAIT;
            OP_READ:   st_d = ST_READ;
            OP_MATCH:  st_d = ST_MATCH;
            OP_SKIP:   st_d = ST_SEL;
            default:   st_d = ST_WAIT;
          endcase
        end
        ST_READ: if (rd_req_i) begin
          if (id_last_i) st_d = ST_SEL;
          else           ptr_inc_o = 1'b1;
        end
        ST_MATCH: if (rx_valid_i) begin
          if (rx_bit_i != id_bit_i) st_d = ST_WAIT;
          else if (id_last_i)       st_d = ST_SEL;
          else                      ptr_inc_o = 1'b1;
        end
        ST_S_TRUE: if (rd_req_i) st_d = ST_S_CMP;
        ST_S_CMP:  if (rd_req_i) st_d = ST_S_DIR;
        ST_S_DIR: if (rx_valid_i) begin
          if (rx_bit_i != id_bit_i) st_d = ST_WAIT;
          else if (id_last_i)       st_d = ST_WAIT;
          else begin
            ptr_inc_o = 1'b1;
            st_d      = ST_S_TRUE;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_WAIT;
    else         st_q <= st_d;
  end

  assign tx_drive_o = (st_q == ST_READ) || (st_q == ST_S_TRUE) || (st_q == ST_S_CMP);
  assign tx_bit_o   = (st_q == ST_S_CMP) ? ~id_bit_i : id_bit_i;
  assign selected_o = (st_q == ST_SEL);
endmodule

// File: rtl/sw_rom_cmd.sv
module sw_rom_cmd
  import sw_rom_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_reset_i,
  input  logic            rx_valid_i,
  input  logic            rx_bit_i,
  input  logic            rd_req_i,
  input  logic            alarm_i,
  input  logic [ID_W-1:0] id_i,
  output logic            tx_drive_o,
  output logic            tx_bit_o,
  output logic            selected_o
);
  rom_st_e          st;
  logic             cmd_en, cmd_done;
  logic [CMD_W-1:0] cmd_byte;
  logic             ptr_clr, ptr_inc, id_bit, id_last;

  sw_rom_cmd_rx #(.W(CMD_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (bus_reset_i),
    .en_i   (cmd_en),
    .bit_i  (rx_bit_i),
    .done_o (cmd_done),
    .byte_o (cmd_byte)
  );

  sw_rom_id_ptr #(.ID_W(ID_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ptr_clr),
    .inc_i  (ptr_inc),
    .id_i   (id_i),
    .bit_o  (id_bit),
    .last_o (id_last)
  );

  sw_rom_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .rx_valid_i  (rx_valid_i),
    .rx_bit_i    (rx_bit_i),
    .rd_req_i    (rd_req_i),
    .alarm_i     (alarm_i),
    .cmd_done_i  (cmd_done),
    .cmd_byte_i  (cmd_byte),
    .id_bit_i    (id_bit),
    .id_last_i   (id_last),
    .st_o        (st),
    .cmd_en_o    (cmd_en),
    .ptr_clr_o   (ptr_clr),
    .ptr_inc_o   (ptr_inc),
    .tx_drive_o  (tx_drive_o),
    .tx_bit_o    (tx_bit_o),
    .selected_o  (selected_o)
  );
endmodule

// File: rtl/sw_rom_chk.sv
module sw_rom_chk
  import sw_rom_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    bus_reset_i,
  input logic    rx_valid_i,
  input logic    rx_bit_i,
  input logic    rd_req_i,
  input logic    tx_drive_o,
  input logic    tx_bit_o,
  input logic    selected_o,
  input rom_st_e st_i
);
  // R11
  rst_clears_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (!selected_o && !tx_drive_o));

  // R2
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (selected_o && !bus_reset_i) |=> selected_o);

  // R6
  srch_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_S_TRUE && rd_req_i && !bus_reset_i)
      |=> (tx_drive_o && (tx_bit_o == !$past(tx_bit_o))));

  // R5
  match_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_MATCH && rx_valid_i && (rx_bit_i != tx_bit_o) && !bus_reset_i)
      |=> (st_i == ST_WAIT && !selected_o));

  // R8
  srch_no_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_S_DIR && rx_valid_i && !bus_reset_i) |=> !selected_o);
endmodule

bind sw_rom_cmd sw_rom_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_reset_i (bus_reset_i),
  .rx_valid_i  (rx_valid_i),
  .rx_bit_i    (rx_bit_i),
  .rd_req_i    (rd_req_i),
  .tx_drive_o  (tx_drive_o),
  .tx_bit_o    (tx_bit_o),
  .selected_o  (selected_o),
  .st_i        (st)
);

// File: tb/sim_sw_rom_cmd.sv
`timescale 1ns/1ps
module sim_sw_rom_cmd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, rd_req = 1'b0;
  logic        alarm = 1'b0;
  logic [63:0] id = 64'h0;
  logic        tx_drive, tx_bit, selected;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sw_rom_cmd u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset), .rx_valid_i(rx_valid),
    .rx_bit_i(rx_bit), .rd_req_i(rd_req), .alarm_i(alarm), .id_i(id),
    .tx_drive_o(tx_drive), .tx_bit_o(tx_bit), .selected_o(selected)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit known_op(input logic [7:0] op);
    return op == 8'hF0 || op == 8'h33 || op == 8'h55 || op == 8'hCC || op == 8'hEC;
  endfunction

  task automatic bus_rst();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_valid = 1'b1; rx_bit = b;
    @(negedge clk); rx_valid = 1'b0; rx_bit = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic read_slot(output logic d, output logic b);
    @(negedge clk); d = tx_drive; b = tx_bit; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic run_read();
    logic d, b;
    bus_rst();
    send_byte(8'h33);
    for (int k = 0; k < 64; k++) begin
      read_slot(d, b);
      chk(d && b == id[k], "R3 id bit", {62'd0, d, b}, {62'd0, 1'b1, id[k]});
    end
    chk(selected == 1'b1, "R3 selected", selected, 1);
  endtask

  task automatic run_match(input int p);
    logic d, b;
    bus_rst();
    send_byte(8'h55);
    for (int k = 0; k < 64; k++) send_bit(id[k] ^ (k == p));
    if (p >= 64) chk(selected == 1'b1, "R4 match selected", selected, 1);
    else begin
      chk(selected == 1'b0, "R5 mismatch not selected", selected, 0);
      read_slot(d, b);
      chk(d == 1'b0, "R5 no drive after mismatch", d, 0);
    end
  endtask

  task automatic run_search(input logic [7:0] op, input int p);
    logic d, b;
    bus_rst();
    send_byte(op);
    for (int k = 0; k < 64; k++) begin
      read_slot(d, b);
      chk(d && b == id[k], "R6 true bit", {62'd0, d, b}, {62'd0, 1'b1, id[k]});
      read_slot(d, b);
      chk(d && b == !id[k], "R6 complement bit", {62'd0, d, b}, {62'd0, 1'b1, !id[k]});
      send_bit(id[k] ^ (k == p));
      if (k == p) break;
    end
    chk(selected == 1'b0, (p >= 64) ? "R8 search end not selected" : "R7 dropout not selected", selected, 0);
    read_slot(d, b);
    chk(d == 1'b0, (p >= 64) ? "R8 no drive after search" : "R7 no drive after dropout", d, 0);
  endtask

  initial begin
    logic d, b;
    logic [7:0] op;
    void'($urandom(32'd4711));
    id = {$urandom(), $urandom()};
    repeat (3) @(negedge clk);
    chk(tx_drive == 1'b0 && selected == 1'b0, "R1 reset outputs", {tx_drive, selected}, 0);
    rst_n = 1'b1;
    send_byte(8'hCC);
    chk(selected == 1'b0, "R1 bits before bus reset ignored", selected, 0);
    read_slot(d, b);
    chk(d == 1'b0, "R1 no drive before bus reset", d, 0);

    bus_rst();
    send_byte(8'hCC);
    chk(selected == 1'b1, "R2 skip selects", selected, 1);
    repeat (5) @(negedge clk);
    chk(selected == 1'b1, "R2 selection held", selected, 1);
    bus_rst();
    chk(selected == 1'b0, "R11 bus reset clears selected", selected, 0);

    for (int r = 0; r < 4; r++) begin
      id = {$urandom(), $urandom()};
      if (r == 0) id = 64'h0;
      if (r == 1) id = '1;
      run_read();
      run_match(64);
      run_match(r == 0 ? 0 : (r == 1 ? 63 : int'($urandom_range(0, 63))));
      run_search(8'hF0, 64);
      run_search(8'hF0, r == 0 ? 0 : (r == 1 ? 63 : int'($urandom_range(0, 63))));
    end

    alarm = 1'b1;
    run_search(8'hEC, 64);
    run_search(8'hEC, 5);
    alarm = 1'b0;
    bus_rst();
    send_byte(8'hEC);
    read_slot(d, b);
    chk(d == 1'b0 && selected == 1'b0, "R9 alarm low no response", {d, selected}, 0);

    for (int r = 0; r < 6; r++) begin
      op = (r == 0) ? 8'h44 : 8'($urandom());
      while (known_op(op)) op = op + 8'd1;
      bus_rst();
      send_byte(op);
      read_slot(d, b);
      chk(d == 1'b0 && selected == 1'b0, "R10 unknown opcode silent", {d, selected}, 0);
    end

    bus_rst();
    send_byte(8'h55);
    for (int k = 0; k < 10; k++) send_bit(id[k]);
    bus_rst();
    send_byte(8'hCC);
    chk(selected == 1'b1, "R11 restart after mid-match reset", selected, 1);
    bus_rst();
    send_byte(8'h33);
    for (int k = 0; k < 3; k++) read_slot(d, b);
    bus_rst();
    chk(tx_drive == 1'b0, "R11 reset stops read", tx_drive, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule